// File: doc/BRIEF.md
# Five-Valued Fault-Pair Gate Evaluator

This block evaluates one logic gate over the five-valued fault algebra used in test
generation. Each signal value stands for a pair: what the line carries in the
fault-free machine and what it carries in the machine with the fault. The five legal
values are 0, 1, X (unknown), D (good 1, faulty 0) and D-bar (good 0, faulty 1). The
block takes two encoded operands and a gate select, and it returns the encoded result
in the same cycle. It is purely combinational.

The evaluator splits each operand into its good half and its faulty half. It runs a
three-valued gate on the good halves and, separately, on the faulty halves. It then
packs the two results back into one code. Because both halves are evaluated, a D and a
D-bar that meet at one gate can cancel to a constant. Any packed pair that is not one
of the five legal values is reported as X. If an operand code is not legal, a flag is
raised. A search engine or a fault simulator would instantiate one evaluator per gate
visit.

Top module: `dval_gate_eval`

## Requirements
- R1: An operand is four bits: the good field in bits [3:2] and the faulty field in bits [1:0]. Each field uses 00 = 0, 01 = 1 and 10 = X. The only legal codes are 0x0 (0), 0x5 (1), 0xA (X), 0x4 (D) and 0x1 (D-bar). The output uses the same codes.
- R2: With select 00 (NAND), an operand equal to 0 forces the output to 1, whatever the other operand is.
- R3: NAND of D with 1 gives D-bar, and NAND of D-bar with 1 gives D.
- R4: NAND of D with D-bar gives 1. NAND of D with D gives D-bar. NAND of D-bar with D-bar gives D.
- R5: NAND of X with 1, with D or with D-bar gives X. NAND of X with X gives X.
- R6: With select 01 (AND), the output is the NAND result with 0 and 1 exchanged and D and D-bar exchanged. In particular, AND of D with D-bar gives 0.
- R7: With select 10 (OR), an operand equal to 1 forces 1. OR of D with D-bar gives 1. OR of D with 0 gives D. OR of D-bar with 0 gives D-bar.
- R8: With select 11 (NOT), the output exchanges 0 and 1 and exchanges D and D-bar, and X stays X. The second operand has no effect on the output or on the error flag.
- R9: err_o is high when the first operand is not a legal code, or when the second operand is not legal and the select is not NOT. While err_o is high, the output is X (0xA).
- R10: The output is always one of the five legal codes. A good/faulty pair outside the legal set (for example good X with faulty 1) is reported as X.
- R11: For NAND, AND and OR, exchanging the two operands does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand code |
| b_i | input | 4 | Second operand code; ignored for NOT |
| op_i | input | 2 | Gate select: 00 NAND, 01 AND, 10 OR, 11 NOT |
| y_o | output | 4 | Result code |
| err_o | output | 1 | Illegal operand code detected |

## Verification
Assertions check several relations on every change of the inputs. The output must always be a legal code. An error must yield X. Under NAND, a 0 operand must dominate, and D meeting D-bar must cancel to 1. Under NOT, the second operand must never raise the error flag. The core also checks that a 0 field dominates its AND. The exact value of every other entry in the tables only shows up in the bench's scenarios. These include the D and D-bar pairs and the mapping of X pairs that are not legal. The bench runs an exhaustive sweep of all codes and selects, random vectors, and directed cases. It compares them with a model that enumerates every concrete good and faulty value behind each X.

// File: rtl/dval_pkg.sv
package dval_pkg;

   localparam int FIELD_W = 2;
   localparam int CODE_W  = 2 * FIELD_W;

   // three-valued field encoding
   localparam logic [FIELD_W-1:0] T_ZERO = 2'b00;
   localparam logic [FIELD_W-1:0] T_ONE  = 2'b01;
   localparam logic [FIELD_W-1:0] T_UNK  = 2'b10;

   // legal five-valued codes {good, faulty}
   localparam logic [CODE_W-1:0] C_ZERO = {T_ZERO, T_ZERO};
   localparam logic [CODE_W-1:0] C_ONE  = {T_ONE,  T_ONE };
   localparam logic [CODE_W-1:0] C_UNK  = {T_UNK,  T_UNK };
   localparam logic [CODE_W-1:0] C_D    = {T_ONE,  T_ZERO};
   localparam logic [CODE_W-1:0] C_DBAR = {T_ZERO, T_ONE };

   typedef enum logic [1:0] {
      OP_NAND = 2'b00,
      OP_AND  = 2'b01,
      OP_OR   = 2'b10,
      OP_NOT  = 2'b11
   } gate_op_e;

   function automatic logic [FIELD_W-1:0] tri_not(input logic [FIELD_W-1:0] v);
      case (v)
         T_ZERO:  tri_not = T_ONE;
         T_ONE:   tri_not = T_ZERO;
         default: tri_not = T_UNK;
      endcase
   endfunction

   function automatic logic [FIELD_W-1:0] tri_and(input logic [FIELD_W-1:0] p,
                                                  input logic [FIELD_W-1:0] q);
      if (p == T_ZERO || q == T_ZERO)     tri_and = T_ZERO;
      else if (p == T_ONE && q == T_ONE)  tri_and = T_ONE;
      else                                tri_and = T_UNK;
   endfunction

   function automatic logic [FIELD_W-1:0] tri_or(input logic [FIELD_W-1:0] p,
                                                 input logic [FIELD_W-1:0] q);
      if (p == T_ONE || q == T_ONE)         tri_or = T_ONE;
      else if (p == T_ZERO && q == T_ZERO)  tri_or = T_ZERO;
      else                                  tri_or = T_UNK;
   endfunction

   function automatic logic code_is_legal(input logic [CODE_W-1:0] c);
      code_is_legal = (c == C_ZERO) || (c == C_ONE) || (c == C_UNK) ||
                      (c == C_D)    || (c == C_DBAR);
   endfunction

endpackage

// File: rtl/dval_decode.sv
module dval_decode
   import dval_pkg::*;
#(
   parameter int FW = FIELD_W,
   localparam int CW = 2 * FW
) (
   input  logic [CW-1:0] code_i,
   output logic          legal_o,
   output logic [FW-1:0] good_o,
   output logic [FW-1:0] faulty_o
);

   if (FW != FIELD_W) begin : g_bad_fw
      $error("dval_decode: field width must match package field width");
   end

   always_comb begin
      legal_o = code_is_legal(code_i);
      if (legal_o) begin
         good_o   = code_i[CW-1:FW];
         faulty_o = code_i[FW-1:0];
      end else begin
         good_o   = T_UNK;
         faulty_o = T_UNK;
      end
   end

endmodule

// File: rtl/dval_tri_core.sv
module dval_tri_core
   import dval_pkg::*;
#(
   parameter int FW          = FIELD_W,
   parameter bit DERIVE_NAND = 1'b1
) (
   input  logic [FW-1:0] x_i,
   input  logic [FW-1:0] y_i,
   input  gate_op_e      op_i,
   output logic [FW-1:0] r_o
);

   if (FW != FIELD_W) begin : g_bad_fw
      $error("dval_tri_core: field width must match package field width");
   end

   if (DERIVE_NAND) begin : g_from_nand
      // every gate built from a three-valued NAND
      logic [FW-1:0] nand_xy, nand_nx_ny;
      always_comb begin
         nand_xy    = tri_not(tri_and(x_i, y_i));
         nand_nx_ny = tri_not(tri_and(tri_not(x_i), tri_not(y_i)));
         case (op_i)
            OP_NAND: r_o = nand_xy;
            OP_AND:  r_o = tri_not(nand_xy);
            OP_OR:   r_o = nand_nx_ny;
            default: r_o = tri_not(x_i);
         endcase
      end
   end else begin : g_direct
      always_comb begin
         case (op_i)
            OP_NAND: r_o = tri_not(tri_and(x_i, y_i));
            OP_AND:  r_o = tri_and(x_i, y_i);
            OP_OR:   r_o = tri_or(x_i, y_i);
            default: r_o = tri_not(x_i);
         endcase
      end
   end

   always_comb begin
      if (op_i == OP_AND && (x_i == T_ZERO || y_i == T_ZERO))
         p_and_zero_field_r6 : assert (r_o == T_ZERO)
            else $error("field AND with a zero operand not zero");
   end

endmodule

// File: rtl/dval_pack.sv
module dval_pack
   import dval_pkg::*;
#(
   parameter int FW = FIELD_W,
   localparam int CW = 2 * FW
) (
   input  logic [FW-1:0] good_i,
   input  logic [FW-1:0] faulty_i,
   input  logic          force_unk_i,
   output logic [CW-1:0] code_o
);

   logic [CW-1:0] raw;

   always_comb begin
      raw = {good_i, faulty_i};
      if (force_unk_i || !code_is_legal(raw)) code_o = C_UNK;
      else                                     code_o = raw;
   end

endmodule

// File: rtl/dval_gate_eval.sv
module dval_gate_eval
   import dval_pkg::*;
#(
   parameter int FW          = FIELD_W,
   parameter bit DERIVE_NAND = 1'b1,
   localparam int CW         = 2 * FW
) (
   input  logic [CW-1:0] a_i,
   input  logic [CW-1:0] b_i,
   input  logic [1:0]    op_i,
   output logic [CW-1:0] y_o,
   output logic          err_o
);

   if (FW != FIELD_W) begin : g_bad_fw
      $error("dval_gate_eval: FW must equal the package field width");
   end

   gate_op_e      op;
   logic          a_ok, b_ok;
   logic [FW-1:0] a_half [2];
   logic [FW-1:0] b_half [2];
   logic [FW-1:0] r_half [2];

   assign op = gate_op_e'(op_i);

   dval_decode #(.FW(FW)) i_dec_a (
      .code_i(a_i), .legal_o(a_ok), .good_o(a_half[1]), .faulty_o(a_half[0]));

   dval_decode #(.FW(FW)) i_dec_b (
      .code_i(b_i), .legal_o(b_ok), .good_o(b_half[1]), .faulty_o(b_half[0]));

   // index 1: fault-free machine, index 0: faulty machine
   for (genvar h = 0; h < 2; h++) begin : g_half
      dval_tri_core #(.FW(FW), .DERIVE_NAND(DERIVE_NAND)) i_core (
         .x_i(a_half[h]), .y_i(b_half[h]), .op_i(op), .r_o(r_half[h]));
   end

   assign err_o = !a_ok || (!b_ok && op != OP_NOT);

   dval_pack #(.FW(FW)) i_pack (
      .good_i(r_half[1]), .faulty_i(r_half[0]), .force_unk_i(err_o), .code_o(y_o));

   always_comb begin
      p_out_legal_r10 : assert (code_is_legal(y_o))
         else $error("output code not legal");
      if (err_o)
         p_err_unknown_r9 : assert (y_o == C_UNK)
            else $error("error without unknown output");
      if (op_i == OP_NAND && !err_o && (a_i == C_ZERO || b_i == C_ZERO))
         p_zero_dominates_r2 : assert (y_o == C_ONE)
            else $error("NAND zero did not force one");
      if (op_i == OP_NAND && ((a_i == C_D && b_i == C_DBAR) ||
                              (a_i == C_DBAR && b_i == C_D)))
         p_d_cancel_r4 : assert (y_o == C_ONE)
            else $error("D and D-bar did not cancel");
      if (op_i == OP_NOT && code_is_legal(a_i))
         p_not_b_ignored_r8 : assert (!err_o)
            else $error("NOT flagged the unused operand");
   end

endmodule

// File: tb/test_dval_gate_eval.sv
module test_dval_gate_eval;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] a, b;
   logic [1:0] op;
   logic [3:0] y;
   logic       err;
   int         n_vec  = 0;
   int         n_fail = 0;
   bit         done   = 1'b0;

   always #10 clk = ~clk;

   dval_gate_eval i_dval_gate_eval (.a_i(a), .b_i(b), .op_i(op), .y_o(y), .err_o(err));

   localparam logic [3:0] V0 = 4'h0, V1 = 4'h5, VX = 4'hA, VD = 4'h4, VB = 4'h1;

   function automatic bit legal(input logic [3:0] c);
      return c == V0 || c == V1 || c == VX || c == VD || c == VB;
   endfunction

   // set of concrete values a field may stand for: bit0 -> 0 possible, bit1 -> 1 possible
   function automatic logic [1:0] field_set(input logic [1:0] f);
      case (f)
         2'b00:   return 2'b01;
         2'b01:   return 2'b10;
         default: return 2'b11;
      endcase
   endfunction

   function automatic logic gate_bit(input logic [1:0] o, input logic p, input logic q);
      case (o)
         2'd0:    return !(p & q);
         2'd1:    return p & q;
         2'd2:    return p | q;
         default: return !p;
      endcase
   endfunction

   function automatic logic [1:0] eval_field(input logic [1:0] o,
                                             input logic [1:0] fa, input logic [1:0] fb);
      logic [1:0] sa, sb, rs;
      sa = field_set(fa);
      sb = (o == 2'd3) ? 2'b01 : field_set(fb);
      rs = 2'b00;
      for (int p = 0; p < 2; p++)
         for (int q = 0; q < 2; q++)
            if (sa[p] && sb[q]) rs[gate_bit(o, p[0], q[0])] = 1'b1;
      if (rs == 2'b01) return 2'b00;
      if (rs == 2'b10) return 2'b01;
      return 2'b10;
   endfunction

   function automatic bit exp_err(input logic [3:0] ea, input logic [3:0] eb,
                                  input logic [1:0] o);
      return !legal(ea) || (o != 2'd3 && !legal(eb));
   endfunction

   function automatic logic [3:0] exp_y(input logic [3:0] ea, input logic [3:0] eb,
                                        input logic [1:0] o);
      logic [3:0] r;
      if (exp_err(ea, eb, o)) return VX;
      r = {eval_field(o, ea[3:2], eb[3:2]), eval_field(o, ea[1:0], eb[1:0])};
      return legal(r) ? r : VX;
   endfunction

   task automatic apply(input logic [3:0] ta, input logic [3:0] tb, input logic [1:0] to);
      @(posedge clk);
      #1;
      a = ta; b = tb; op = to;
      @(negedge clk);
   endtask

   task automatic check_y(input string req, input logic [3:0] want);
      n_vec++;
      if (y !== want) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h op=%0d y=%h expected %h", req, a, b, op, y, want);
      end
   endtask

   task automatic check_err(input string req, input logic want);
      n_vec++;
      if (err !== want) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h op=%0d err=%0b expected %0b", req, a, b, op, err, want);
      end
   endtask

   task automatic vec(input string req, input logic [3:0] ta, input logic [3:0] tb,
                      input logic [1:0] to, input logic [3:0] want);
      apply(ta, tb, to);
      check_y(req, want);
   endtask

   initial begin
      a = V0; b = V0; op = 2'd0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 R2 reset-state operands: NAND of 0,0
      check_y("R2", V1);
      check_err("R1", 1'b0);

      vec("R2", V0, VX, 2'd0, V1);
      vec("R2", VD, V0, 2'd0, V1);
      vec("R3", VD, V1, 2'd0, VB);
      vec("R3", V1, VB, 2'd0, VD);
      vec("R4", VD, VB, 2'd0, V1);
      vec("R4", VD, VD, 2'd0, VB);
      vec("R4", VB, VB, 2'd0, VD);
      vec("R5", VX, V1, 2'd0, VX);
      vec("R5", VX, VD, 2'd0, VX);
      vec("R5", VB, VX, 2'd0, VX);
      vec("R6", VD, VB, 2'd1, V0);
      vec("R6", VD, V1, 2'd1, VD);
      vec("R7", VD, VB, 2'd2, V1);
      vec("R7", VD, V0, 2'd2, VD);
      vec("R7", V0, VB, 2'd2, VB);
      vec("R7", V1, VX, 2'd2, V1);
      vec("R8", VD, VX, 2'd3, VB);
      vec("R8", V0, 4'hF, 2'd3, V1);
      check_err("R8", 1'b0);
      vec("R9", 4'h2, V1, 2'd0, VX);
      check_err("R9", 1'b1);
      vec("R9", V1, 4'hB, 2'd2, VX);
      check_err("R9", 1'b1);
      vec("R10", VX, VB, 2'd1, VX);

      // exhaustive sweep of all codes and selects
      for (int o = 0; o < 4; o++)
         for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
               apply(i[3:0], j[3:0], o[1:0]);
               check_y("R10", exp_y(i[3:0], j[3:0], o[1:0]));
               check_err("R9", exp_err(i[3:0], j[3:0], o[1:0]));
            end

      // R11 operand exchange with random legal codes
      begin
         logic [3:0] pool [5];
         logic [3:0] ra, rb, first;
         logic [1:0] ro;
         int unused_seed;
         pool[0] = V0; pool[1] = V1; pool[2] = VX; pool[3] = VD; pool[4] = VB;
         unused_seed = $urandom(32'h5eed);
         for (int k = 0; k < 600; k++) begin
            ra = pool[$urandom_range(4)];
            rb = pool[$urandom_range(4)];
            ro = 2'($urandom_range(2));
            apply(ra, rb, ro);
            check_y("R11", exp_y(ra, rb, ro));
            first = y;
            apply(rb, ra, ro);
            check_y("R11", first);
         end
         for (int k = 0; k < 800; k++) begin
            ra = 4'($urandom);
            rb = 4'($urandom);
            ro = 2'($urandom);
            apply(ra, rb, ro);
            check_y("R1", exp_y(ra, rb, ro));
            check_err("R9", exp_err(ra, rb, ro));
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule